// File: doc/BRIEF.md
# Quad-Channel Pulse-Width Modulator with Coarse Prescaler

This block generates four independent pulse-width modulated outputs from a single clock. Software sets it up through a small word-addressed register interface. A shared control word holds one run bit and one two-bit prescale code for each channel. Each channel also has its own word that holds a period count and a high-time count. Both counts are measured in prescaled steps.

Each channel has a prescaler that divides the clock by 1, 8, 64 or 512 and so produces step ticks. A step counter walks from 0 to period-1 and then wraps. The output is high while the step is below the high-time count. The period and high-time values that are in use are copied from the registers at each wrap, so a value rewritten mid-cycle never cuts a pulse short. The register interface is a plain write strobe with combinational readback. It has no handshake, because it only moves configuration.

Top module: `pwm_quad`

## Requirements
- R1: After reset every register reads zero and all four outputs are low.
- R2: The control word is at byte offset 0x00. Bit n (n = 0..3) is the run bit of channel n, and bits 2n+5:2n+4 are the prescale code of channel n. The word of channel n is at byte offset 0x04+4n, with the period in bits 7:0 and the high-time in bits 23:16. Every other bit reads as zero. Registers read back what was written. Reads of offset 0x14 and above return zero. Writes to an address whose two low bits are not zero change nothing.
- R3: Prescale code 0 advances the step every clock, code 1 every 8 clocks, code 2 every 64 clocks and code 3 every 512 clocks.
- R4: A running channel with period P > 0 repeats every P steps. Its output is high exactly while the step index within the cycle is below the high-time count.
- R5: A high-time of 0 gives a constant low output. A high-time equal to or above the period gives a constant high output.
- R6: A period of 0 holds the output low whatever the high-time.
- R7: Setting a run bit starts a fresh cycle at step 0. The output is high on the first clock after the write if the high-time is nonzero.
- R8: A period or high-time written while a channel runs takes effect at the next cycle boundary. The cycle in progress finishes with the old values.
- R9: A channel whose run bit is clear drives its output low. Clearing one channel's run bit leaves the other control bits and the other channels' waveforms unchanged.
- R10: All four channels run at once with independent settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | 4 | PWM outputs, bit n belongs to channel n |

## Verification
A step counter that slips or wraps at the wrong place changes the pulse width or the repeat length of its channel. That shows on pwm_out within one PWM cycle, which can be up to 255×512 clocks at the coarsest code. A prescaler with the wrong ratio moves the first falling edge after enable away from high-time×ratio clocks, so it shows within the first pulse. A stale or early-loaded copy of the period and high-time shows as a wrong pulse in the cycle right after a mid-run write. The bench compares every output against an expected waveform on every clock for this reason.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int NUM_CH_D  = 4;
  localparam int STEP_W_D  = 8;
  localparam int ADDR_W_D  = 5;
  localparam int DATA_W_D  = 32;
  localparam int PRE_W     = 9;   // holds the largest divide limit, 511
  localparam int SEL_W     = 2;
  localparam int SEL_LSB   = 4;   // code of channel n sits at SEL_LSB + 2n
  localparam int DUTY_LSB  = 16;

  typedef enum logic [SEL_W-1:0] {
    PS_DIV1   = 2'd0,
    PS_DIV8   = 2'd1,
    PS_DIV64  = 2'd2,
    PS_DIV512 = 2'd3
  } ps_sel_e;

  // terminal count of the prescaler: ratio - 1
  function automatic logic [PRE_W-1:0] ps_limit(input logic [SEL_W-1:0] sel);
    case (ps_sel_e'(sel))
      PS_DIV1:  ps_limit = PRE_W'(0);
      PS_DIV8:  ps_limit = PRE_W'(7);
      PS_DIV64: ps_limit = PRE_W'(63);
      default:  ps_limit = PRE_W'(511);
    endcase
  endfunction
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = NUM_CH_D,
  parameter int STEP_W = STEP_W_D,
  parameter int ADDR_W = ADDR_W_D,
  parameter int DATA_W = DATA_W_D
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic [NUM_CH-1:0]               ch_run,
  output logic [NUM_CH-1:0][SEL_W-1:0]    ch_sel,
  output logic [NUM_CH-1:0][STEP_W-1:0]   ch_per,
  output logic [NUM_CH-1:0][STEP_W-1:0]   ch_duty
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int CTRL_W = SEL_LSB + SEL_W * NUM_CH;

  logic             aligned;
  logic [IDX_W-1:0] idx;
  logic             unused_wdata;

  assign aligned = (addr[1:0] == 2'b00);
  assign idx     = addr[ADDR_W-1:2];
  assign unused_wdata = ^{wdata[DATA_W-1:DUTY_LSB+STEP_W], wdata[DUTY_LSB-1:CTRL_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_run <= '0;
      ch_sel <= '0;
    end else if (wr_en && aligned && idx == '0) begin
      ch_run <= wdata[NUM_CH-1:0];
      for (int n = 0; n < NUM_CH; n++)
        ch_sel[n] <= wdata[SEL_LSB + SEL_W*n +: SEL_W];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_per[g]  <= '0;
        ch_duty[g] <= '0;
      end else if (wr_en && aligned && idx == IDX_W'(g + 1)) begin
        ch_per[g]  <= wdata[STEP_W-1:0];
        ch_duty[g] <= wdata[DUTY_LSB +: STEP_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      if (idx == '0) begin
        rdata[NUM_CH-1:0] = ch_run;
        for (int n = 0; n < NUM_CH; n++)
          rdata[SEL_LSB + SEL_W*n +: SEL_W] = ch_sel[n];
      end
      for (int n = 0; n < NUM_CH; n++) begin
        if (idx == IDX_W'(n + 1)) begin
          rdata[STEP_W-1:0]          = ch_per[n];
          rdata[DUTY_LSB +: STEP_W]  = ch_duty[n];
        end
      end
    end
  end

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && aligned && idx == '0) |=> (ch_run == $past(wdata[NUM_CH-1:0])));

  // R2
  misaligned_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !aligned) |=> ($stable(ch_run) && $stable(ch_sel) && $stable(ch_per) && $stable(ch_duty)));
endmodule

// File: rtl/pwm_quad_prescale.sv
module pwm_quad_prescale
  import pwm_quad_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] limit;

  assign limit = ps_limit(sel);
  // >= so that a code lowered mid-run cannot strand the counter above the limit
  assign tick  = run && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R3
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $stable(sel)) |-> (cnt <= limit));

  // R3
  div1_every_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && sel == PS_DIV1 && $past(sel) == PS_DIV1) |-> tick);
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [STEP_W-1:0] per_in,
  input  logic [STEP_W-1:0] duty_in,
  output logic              pwm
);
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] act_per;
  logic [STEP_W-1:0] act_duty;
  logic              wrap;

  assign wrap = (act_per == '0) || ({1'b0, step} + 1'b1 >= {1'b0, act_per});
  assign pwm  = run && (act_per != '0) && (step < act_duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= '0;
      act_per  <= '0;
      act_duty <= '0;
    end else if (!run) begin
      step     <= '0;
      act_per  <= per_in;
      act_duty <= duty_in;
    end else if (tick) begin
      if (wrap) begin
        step     <= '0;
        act_per  <= per_in;
        act_duty <= duty_in;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_per != '0) |-> (step < act_per));

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(tick && wrap)) |-> ($stable(act_per) && $stable(act_duty)));

  // R9
  idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> (step == '0));

  // R5
  full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_per != '0 && act_duty >= act_per) |-> pwm);
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = NUM_CH_D,
  parameter int STEP_W = STEP_W_D,
  parameter int ADDR_W = ADDR_W_D,
  parameter int DATA_W = DATA_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [NUM_CH-1:0]             run;
  logic [NUM_CH-1:0][SEL_W-1:0]  sel;
  logic [NUM_CH-1:0][STEP_W-1:0] per;
  logic [NUM_CH-1:0][STEP_W-1:0] duty;
  logic [NUM_CH-1:0]             tick;

  pwm_quad_regs #(
    .NUM_CH(NUM_CH), .STEP_W(STEP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .ch_run(run), .ch_sel(sel), .ch_per(per), .ch_duty(duty)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_quad_prescale u_pre (
      .clk(clk), .rst_n(rst_n), .run(run[g]), .sel(sel[g]), .tick(tick[g])
    );
    pwm_quad_chan #(.STEP_W(STEP_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .run(run[g]), .tick(tick[g]),
      .per_in(per[g]), .duty_in(duty[g]), .pwm(pwm_out[g])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> (pwm_out == '0));
endmodule

// File: tb/sim_pwm_quad.sv
module sim_pwm_quad;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] ctrl_sh = '0;
  int b_on[4], b_ratio[4], b_per[4], b_duty[4], b_base[4];

  pwm_quad u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic bit exp_out(int ch, int i);
    int s;
    if (b_on[ch] == 0 || b_per[ch] == 0) return 1'b0;
    s = ((i - b_base[ch]) / b_ratio[ch]) % b_per[ch];
    return (s < b_duty[ch]);
  endfunction

  // compares all outputs for cycles start..start+n-1, one sample per falling edge
  task automatic run_cmp(input int start, input int n, input string tag);
    for (int i = start; i < start + n; i++) begin
      for (int c = 0; c < 4; c++) begin
        bit e;
        e = exp_out(c, i);
        if (pwm_out[c] !== e) begin
          chk(1'b0, $sformatf("%s ch%0d cyc%0d", tag, c, i), pwm_out[c], e);
        end
      end
      n_chk++;
      @(negedge clk);
    end
  endtask

  task automatic all_off();
    wr(5'h00, 32'h0);
    ctrl_sh = '0;
    for (int c = 0; c < 4; c++) begin
      b_on[c] = 0; b_ratio[c] = 1; b_per[c] = 0; b_duty[c] = 0; b_base[c] = 0;
    end
  endtask

  task automatic cfg(input int c, input int ratio, input int code, input int per, input int duty);
    wr(5'(4 + 4*c), {8'h0, 8'(duty), 8'h0, 8'(per)});
    ctrl_sh[5 + 2*c -: 2] = 2'(code);
    ctrl_sh[c] = 1'b1;
    b_on[c] = 1; b_ratio[c] = ratio; b_per[c] = per; b_duty[c] = duty; b_base[c] = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(pwm_out == 4'h0, "R1 outputs", pwm_out, 0);
    for (int a = 0; a <= 16; a += 4) begin
      rd(5'(a), d);
      chk(d == 32'h0, $sformatf("R1 reg %0h", a), d, 0);
    end
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, d); chk(d == 32'h00FF_00FF, "R2 cfg0 pad", d, 32'h00FF_00FF);
    wr(5'h10, 32'h1234_5678);
    rd(5'h10, d); chk(d == 32'h0034_0078, "R2 cfg3 fields", d, 32'h0034_0078);
    wr(5'h05, 32'h0000_0011);
    rd(5'h04, d); chk(d == 32'h00FF_00FF, "R2 misaligned ignored", d, 32'h00FF_00FF);
    wr(5'h00, 32'hFFFF_FFF0);
    rd(5'h00, d); chk(d == 32'h0000_0FF0, "R2 ctrl", d, 32'h0000_0FF0);
    chk(pwm_out == 4'h0, "R9 no run bits", pwm_out, 0);
    rd(5'h14, d); chk(d == 32'h0, "R2 unmapped", d, 0);
    wr(5'h04, 0); wr(5'h10, 0);
    all_off();
  endtask

  task automatic t_div1();
    all_off();
    cfg(0, 1, 0, 10, 3);
    wr(5'h00, ctrl_sh);
    chk(pwm_out[0] == 1'b1, "R7 first step high", pwm_out[0], 1);
    run_cmp(0, 40, "R4 div1");
  endtask

  task automatic t_prescale();
    all_off();
    cfg(1, 8, 1, 5, 2);
    wr(5'h00, ctrl_sh);
    run_cmp(0, 100, "R3 div8 ch1");
    all_off();
    cfg(2, 64, 2, 4, 1);
    wr(5'h00, ctrl_sh);
    run_cmp(0, 600, "R3 div64 ch2");
    all_off();
    cfg(3, 512, 3, 3, 2);
    wr(5'h00, ctrl_sh);
    run_cmp(0, 3200, "R3 div512 ch3");
  endtask

  task automatic t_duty_edges();
    all_off();
    cfg(0, 1, 0, 6, 0);
    cfg(1, 1, 0, 6, 6);
    cfg(2, 1, 0, 6, 200);
    cfg(3, 8, 1, 1, 1);
    wr(5'h00, ctrl_sh);
    run_cmp(0, 30, "R5 duty edges");
  endtask

  task automatic t_period0();
    all_off();
    cfg(0, 1, 0, 0, 9);
    cfg(2, 8, 1, 0, 255);
    wr(5'h00, ctrl_sh);
    run_cmp(0, 40, "R6 period zero");
  endtask

  task automatic t_update();
    all_off();
    cfg(1, 1, 0, 10, 3);
    wr(5'h00, ctrl_sh);
    run_cmp(0, 13, "R8 before write");
    wr(5'h08, {8'h0, 8'd5, 8'h0, 8'd6});
    run_cmp(14, 6, "R8 old values kept");
    b_per[1] = 6; b_duty[1] = 5; b_base[1] = 20;
    run_cmp(20, 30, "R8 new values");
  endtask

  task automatic t_disable();
    logic [31:0] d;
    all_off();
    cfg(0, 8, 1, 7, 3);
    cfg(2, 1, 0, 4, 2);
    wr(5'h00, ctrl_sh);
    run_cmp(0, 8, "R9 both on");
    ctrl_sh[0] = 1'b0;
    wr(5'h00, ctrl_sh);
    b_on[0] = 0;
    rd(5'h00, d);
    chk(d == 32'h0000_0014, "R9 other bits kept", d, 32'h14);
    run_cmp(9, 40, "R9 off low, ch2 undisturbed");
  endtask

  task automatic t_multi();
    all_off();
    cfg(0, 1, 0, 5, 2);
    cfg(1, 1, 0, 7, 4);
    cfg(2, 8, 1, 3, 1);
    cfg(3, 64, 2, 2, 1);
    wr(5'h00, ctrl_sh);
    run_cmp(0, 400, "R10 four channels");
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      b_on[c] = 0; b_ratio[c] = 1; b_per[c] = 0; b_duty[c] = 0; b_base[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_div1();
    t_prescale();
    t_duty_edges();
    t_period0();
    t_update();
    t_disable();
    t_multi();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule